// File: doc/BRIEF.md
# Internal Periodic Update Generator

This block produces a self-timed update strobe, so the chip does not need an external controller to pulse an update line. A base tick runs at one quarter of the system clock. A 2-bit rate field divides that tick further by 1, 2, 4 or 8. The divided tick advances a 32-bit counter, and a programmable terminal value sets where that counter wraps. Each wrap raises a one-cycle internal update enable for the parameter consumers downstream.

At the same time the block drives an active-high pin strobe that lasts 12 system clocks, which tells external logic that an update has just happened. The pin is driven only while the internal mode is enabled. If the terminal value is 3 or less, the pin holds a constant logic 1 and does not pulse.

Any change to the rate field or the terminal value restarts the whole timing chain from zero. Turning the mode on also starts the chain from zero.

Top module: `periodic_update_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released with `enable` low, `upd_event`, `strobe_out` and `strobe_oe` are all 0.
- R2: While `enable` is low, `strobe_oe` and `strobe_out` are 0 and no `upd_event` occurs.
- R3: While `enable` is high, `strobe_oe` is 1.
- R4: With `term_count` = B ≥ 1 and `rate_sel` = A, `upd_event` is high for exactly one cycle every 4·2^A·B clocks.
- R5: `rate_sel` is read as an unsigned exponent. The values 0, 1, 2 and 3 select divisors of 1, 2, 4 and 8 applied after the fixed divide-by-4.
- R6: When `term_count` ≥ 4, `strobe_out` goes high in the same cycle as `upd_event` and stays high for exactly 12 cycles. It is low at all other times.
- R7: When `enable` is high and `term_count` ≤ 3, `strobe_out` is constantly 1.
- R8: When `term_count` = 0, no `upd_event` is ever produced.
- R9: Let E0 be the first clock edge that samples a changed `rate_sel` or `term_count`. E0 restarts the timing chain and clears any strobe in progress. The next `upd_event` then appears 4·2^A·B cycles after E0, using the new values.
- R10: Let E0 be the first clock edge that samples `enable` high. The first `upd_event` appears 4·2^A·B cycles after E0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Turns on internal update generation and pin drive |
| rate_sel | input | 2 | Exponent A of the extra power-of-two divider |
| term_count | input | 32 | Terminal count B of the wrap counter |
| upd_event | output | 1 | One-cycle internal update enable |
| strobe_out | output | 1 | Stretched update strobe driven onto the pin |
| strobe_oe | output | 1 | Output enable for the update pin |

## Verification
The hardest case to reach from the ports is a restart in the middle of a period. The prescaler and the wrap counter must both hold a partial count at the moment the configuration changes, and a wrong restart shows up only as an event that arrives a few cycles off. To reach it, the stimulus loads a long terminal value and changes it well before the first wrap. In a second step it changes only the rate field. Each event is then checked against the exact cycle predicted from the edge that sampled the change.

// File: rtl/pug_pkg.sv
package pug_pkg;

    localparam int unsigned CNT_W      = 32;
    localparam int unsigned RATE_W     = 2;
    localparam int unsigned BASE_DIV   = 4;
    localparam int unsigned PULSE_LEN  = 12;
    localparam int unsigned STATIC_MAX = 3;

    localparam int unsigned MAX_DIV = BASE_DIV << ((1 << RATE_W) - 1);
    localparam int unsigned PRE_W   = $clog2(MAX_DIV);
    localparam int unsigned LIM_W   = PRE_W + 1;
    localparam int unsigned STR_W   = $clog2(PULSE_LEN + 1);

    typedef logic [RATE_W-1:0] rate_t;
    typedef logic [CNT_W-1:0]  term_t;

    typedef struct packed {
        rate_t rate;
        term_t term;
    } cfg_t;

    typedef enum logic [1:0] {
        DRV_OFF   = 2'd0,
        DRV_PULSE = 2'd1,
        DRV_HOLD  = 2'd2
    } drive_e;

    // Number of system clocks per divided tick
    function automatic logic [LIM_W-1:0] pre_limit(rate_t a);
        return LIM_W'(BASE_DIV) << a;
    endfunction

    function automatic logic is_static(term_t b);
        return b <= term_t'(STATIC_MAX);
    endfunction

    function automatic drive_e pick_drive(logic en, term_t b);
        if (!en)
            return DRV_OFF;
        else if (is_static(b))
            return DRV_HOLD;
        else
            return DRV_PULSE;
    endfunction

endpackage

// File: rtl/pug_prescaler.sv
module pug_prescaler
    import pug_pkg::*;
#(
    parameter int unsigned P_RATE_W = RATE_W,
    parameter int unsigned P_PRE_W  = PRE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic [P_RATE_W-1:0] rate,
    output logic                tick
);
    localparam int unsigned L_W = P_PRE_W + 1;

    logic [P_PRE_W-1:0] cnt_q;
    logic [L_W-1:0]     lim;

    always_comb begin
        lim  = L_W'(pre_limit(rate_t'(rate)));
        tick = ({1'b0, cnt_q} == (lim - L_W'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + P_PRE_W'(1);
    end

endmodule

// File: rtl/pug_term_counter.sv
module pug_term_counter
    import pug_pkg::*;
#(
    parameter int unsigned P_CNT_W = CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               tick,
    input  logic [P_CNT_W-1:0] term,
    output logic               fire
);
    logic [P_CNT_W-1:0] cnt_q;
    logic               at_end;

    always_comb begin
        at_end = (term != '0) && (cnt_q == term - P_CNT_W'(1));
        fire   = tick && at_end;
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= at_end ? '0 : cnt_q + P_CNT_W'(1);
    end

endmodule

// File: rtl/pug_stretcher.sv
module pug_stretcher
    import pug_pkg::*;
#(
    parameter int unsigned P_LEN = PULSE_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic start,
    output logic active
);
    localparam int unsigned W = $clog2(P_LEN + 1);

    logic [W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            left_q <= '0;
        else if (start)
            left_q <= W'(P_LEN);
        else if (left_q != '0)
            left_q <= left_q - W'(1);
    end

    assign active = (left_q != '0);

endmodule

// File: rtl/periodic_update_gen.sv
module periodic_update_gen
    import pug_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [CNT_W-1:0]  term_count,
    output logic              upd_event,
    output logic              strobe_out,
    output logic              strobe_oe
);
    cfg_t   cfg_now, cfg_q;
    logic   en_q;
    logic   restart;
    logic   tick, fire, start, pulse_on;
    drive_e drv;

    always_comb begin
        cfg_now.rate = rate_sel;
        cfg_now.term = term_count;
        restart      = !enable || !en_q || (cfg_now != cfg_q);
        start        = fire && !restart;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            en_q      <= 1'b0;
            upd_event <= 1'b0;
        end else begin
            cfg_q     <= cfg_now;
            en_q      <= enable;
            upd_event <= start;
        end
    end

    pug_prescaler #(.P_RATE_W(RATE_W), .P_PRE_W(PRE_W)) pre_i (
        .clk   (clk),
        .rst   (rst),
        .clear (restart),
        .rate  (rate_sel),
        .tick  (tick)
    );

    pug_term_counter #(.P_CNT_W(CNT_W)) cnt_i (
        .clk   (clk),
        .rst   (rst),
        .clear (restart),
        .tick  (tick),
        .term  (term_count),
        .fire  (fire)
    );

    pug_stretcher #(.P_LEN(PULSE_LEN)) str_i (
        .clk    (clk),
        .rst    (rst),
        .clear  (restart),
        .start  (start),
        .active (pulse_on)
    );

    always_comb begin
        drv = pick_drive(enable && !rst, term_count);
        unique case (drv)
            DRV_HOLD:  strobe_out = 1'b1;
            DRV_PULSE: strobe_out = pulse_on;
            default:   strobe_out = 1'b0;
        endcase
        strobe_oe = (drv != DRV_OFF);
    end

endmodule

// File: rtl/periodic_update_gen_chk.sv
module periodic_update_gen_chk
    import pug_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic [RATE_W-1:0] rate_sel,
    input logic [CNT_W-1:0]  term_count,
    input logic              upd_event,
    input logic              strobe_out,
    input logic              strobe_oe
);
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !upd_event);

    a_r2_off_no_event: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !upd_event);

    a_r2_off_no_drive: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !strobe_out);

    a_r4_single_cycle: assert property (@(posedge clk) disable iff (rst)
        upd_event |=> !upd_event);

    a_r6_strobe_with_event: assert property (@(posedge clk) disable iff (rst)
        (upd_event && enable) |-> strobe_out);

    a_r3_drive_on_event: assert property (@(posedge clk) disable iff (rst)
        upd_event |-> strobe_oe);

    a_r8_zero_term: assert property (@(posedge clk) disable iff (rst)
        (enable && term_count == '0 && $stable(term_count)) |=> !upd_event);

    a_r9_restart: assert property (@(posedge clk) disable iff (rst)
        !$stable(term_count) |=> !upd_event);

endmodule

bind periodic_update_gen periodic_update_gen_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .rate_sel   (rate_sel),
    .term_count (term_count),
    .upd_event  (upd_event),
    .strobe_out (strobe_out),
    .strobe_oe  (strobe_oe)
);

// File: tb/periodic_update_gen_tb_top.sv
`timescale 1ns/1ps
module periodic_update_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic [1:0]  rate_sel;
    logic [31:0] term_count;
    logic        upd_event, strobe_out, strobe_oe;

    always #2 clk = ~clk;   // 250 MHz

    periodic_update_gen dut_i (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .rate_sel   (rate_sel),
        .term_count (term_count),
        .upd_event  (upd_event),
        .strobe_out (strobe_out),
        .strobe_oe  (strobe_oe)
    );

    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    int    exp_q[$];
    int    last_ev = -1000;
    bit    mon_on = 1'b0;
    bit    m_en = 1'b0;
    int    m_b = 0;
    bit    done = 1'b0;
    string tag = "R1";

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares outputs against the expected queue every cycle
    always @(negedge clk) begin
        bit   due;
        logic exp_s;
        if (mon_on) begin
            due = (exp_q.size() > 0) && (exp_q[0] == cyc);
            if (due) begin
                void'(exp_q.pop_front());
                last_ev = cyc;
            end
            n_cmp++;
            if (upd_event !== due) begin
                n_bad++;
                $display("FAIL %s: upd_event at cycle %0d got %b expected %b", tag, cyc, upd_event, due);
            end
            exp_s = m_en && (m_b <= 3 || (last_ev >= 0 && cyc - last_ev < 12));
            n_cmp++;
            if (strobe_out !== exp_s) begin
                n_bad++;
                $display("FAIL R6/R7 (%s): strobe_out at cycle %0d got %b expected %b", tag, cyc, strobe_out, exp_s);
            end
            n_cmp++;
            if (strobe_oe !== m_en) begin
                n_bad++;
                $display("FAIL R3 (%s): strobe_oe at cycle %0d got %b expected %b", tag, cyc, strobe_oe, m_en);
            end
        end
    end

    // Driver: applies a setting and queues the cycles where events are due
    task automatic apply(input bit en, input int a, input int b, input int hold, input string t);
        int m;
        int lim;
        @(negedge clk);
        #1;
        m          = cyc;
        enable     = en;
        rate_sel   = 2'(a);
        term_count = 32'(b);
        exp_q.delete();
        last_ev    = -1000;
        m_en       = en;
        m_b        = b;
        tag        = t;
        if (en && b >= 1) begin
            lim = (4 << a) * b;
            for (int k = 1; m + 1 + k * lim <= m + hold + 1; k++)
                exp_q.push_back(m + 1 + k * lim);
        end
        repeat (hold) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; enable = 1'b0; rate_sel = '0; term_count = '0;
        repeat (3) @(negedge clk);
        n_cmp++;
        if (upd_event !== 1'b0 || strobe_out !== 1'b0 || strobe_oe !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: outputs in reset got %b%b%b expected 000", upd_event, strobe_out, strobe_oe);
        end
        #1 rst = 1'b0;
        @(negedge clk);
        n_cmp++;
        if (upd_event !== 1'b0 || strobe_out !== 1'b0 || strobe_oe !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: outputs after reset got %b%b%b expected 000", upd_event, strobe_out, strobe_oe);
        end
        mon_on = 1'b1;
        apply(1, 0, 4,  70,  "R4");
        apply(1, 1, 5,  130, "R5");
        apply(1, 3, 4,  300, "R5");
        apply(1, 2, 7,  250, "R4");
        apply(0, 2, 7,  60,  "R2");
        apply(1, 0, 3,  40,  "R7");
        apply(1, 1, 1,  30,  "R7");
        apply(1, 0, 0,  40,  "R8");
        apply(1, 0, 10, 25,  "R9");
        apply(1, 0, 6,  60,  "R9");
        apply(1, 2, 6,  200, "R9");
        apply(0, 2, 6,  5,   "R2");
        apply(1, 0, 5,  50,  "R10");
        mon_on = 1'b0;
        done   = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (%s): run hung got timeout expected completion", tag);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule